// File: doc/BRIEF.md
# Power Good and Fault Supervisor

This block sits beside a single-phase hysteretic core regulator and turns a set of comparator results and event strobes into two power-good indications and a gate-control fault command. Every time base inside it is a count of switching cycles, delivered as a one-cycle strobe, rather than a count of clock cycles. Three things are measured that way: the blanking window after a reference change, the settling delay before the late power-good, and the run of current-limit pulses that leads to a trip.

The early power-good follows the output-window comparator once start-up has reached its boot level. It is held asserted while a reference transition is being blanked. The late power-good follows the early one, but only after a fixed number of switching cycles has elapsed since the early one first asserted. Three protection latches are kept: window over-voltage, sustained current limit and over-temperature. Each one is qualified by the operating phase, and all three clear only when the regulator is disabled or its supply drops out. All pins are plain level or strobe signals. No data stream passes through the block, so it has no handshake and no back-pressure.

Top module: `pg_fault_supervisor`

## Requirements
- R1: While `en` is low or `uvlo` is high, `pg_early` and `pg_late` are 0 one clock later, and `gate_cmd` is 3'b001 (all gates off) in the same cycle. After reset both power-good outputs are 0.
- R2: Once `boot_reached` has been seen high since the block was enabled, `pg_early` equals `win_ok` delayed by one clock, except as stated in R4 and R11. Before that, `pg_early` stays 0.
- R3: `pg_late` becomes 1 once 1007 `cyc_tick` strobes have been counted, starting from the first cycle in which `pg_early` is 1. From then on it equals `pg_early` until the block is disabled or in lockout.
- R4: A rising edge of `trans_act` starts a blanking window that lasts 62 `cyc_tick` strobes. While the window is open, a started block drives `pg_early` to 1 whatever `win_ok` shows.
- R5: `win_hi` sets the over-voltage latch only while `ss_done` is 1, `trans_act` is 0 and no blanking window is open. The latched state drives `gate_cmd` = 3'b010 (hold the low-side gate on).
- R6: `ovp_abs` sets the over-voltage latch in any phase, including during soft-start and transitions.
- R7: With `win_lo` and `ss_done` both 1, 32 consecutive `cyc_tick` strobes that each carry `ilim_evt` set the current-limit latch, which drives `gate_cmd` = 3'b001. The run counter returns to zero on a tick without `ilim_evt`, when `win_lo` falls, or when `ss_done` is 0.
- R8: `otemp` sets the over-temperature latch, which drives `gate_cmd` = 3'b001. It takes priority over the over-voltage latch.
- R9: Every latch persists until `en` goes low or `uvlo` goes high. Lockout is not latched itself: normal operation resumes once `uvlo` falls.
- R10: `gate_cmd` is one-hot or zero, with priority off/lockout, over-temperature, over-voltage, current limit. Otherwise a live `ilim_evt` gives 3'b100 (high-side off for this cycle), and with none of these it is 3'b000.
- R11: While any latch is set, `pg_early` and `pg_late` are 0 from the following clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; low clears all latches |
| uvlo | input | 1 | Supply lockout; high clears all latches |
| cyc_tick | input | 1 | One-cycle strobe per switching cycle |
| win_ok | input | 1 | Output within ±14% of reference |
| win_hi | input | 1 | Output above +14% of reference |
| win_lo | input | 1 | Output below −14% of reference |
| ovp_abs | input | 1 | Output above fixed 2.0 V level |
| ilim_evt | input | 1 | Current-limit event in this switching cycle |
| otemp | input | 1 | Over-temperature |
| ss_done | input | 1 | Soft-start finished |
| trans_act | input | 1 | Reference (VID or sleep) transition in progress |
| boot_reached | input | 1 | Start-up has held boot level for the boot period |
| pg_early | output | 1 | Early power-good, active high |
| pg_late | output | 1 | Delayed power-good, active high |
| gate_cmd | output | 3 | Fault command: bit0 all off, bit1 hold low, bit2 high-side off |

## Verification
The hardest state to reach is the point just before the current-limit trip. The run must climb to 31 pulses, break, and then climb again to exactly 32. The stimulus holds `win_lo` and `ss_done` high with a tick on every clock and keeps `ilim_evt` asserted for exact cycle counts. It also drops a single tick without an event, and separately drops `win_lo` for one cycle, to show that a near-complete run restarts from zero. Blanking is exercised with ticks on every other clock, so that its length is shown to follow switching cycles and not clocks. A window over-voltage is presented inside that window, where it must be ignored.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'b000,
    CMD_ALL_OFF  = 3'b001,
    CMD_HOLD_LOW = 3'b010,
    CMD_HS_OFF   = 3'b100
  } gate_cmd_e;
endpackage

// File: rtl/pgs_blank_timer.sv
module pgs_blank_timer #(
  parameter int BLANK_CYC = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trans_act,
  input  logic tick,
  output logic blanking
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic          trans_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise     = trans_act & ~trans_q;
  assign blanking = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      trans_q <= trans_act;
      if (clr)                   cnt_q <= '0;
      else if (rise)             cnt_q <= LOAD;
      else if (tick && blanking) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  blank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr) |=> blanking);
endmodule

// File: rtl/pgs_delay_timer.sv
module pgs_delay_timer #(
  parameter int DLY_CYC = 1007
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pg_early,
  input  logic tick,
  output logic armed
);
  localparam int CW = $clog2(DLY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = seen_q | pg_early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      armed  <= 1'b0;
    end else if (clr) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      armed  <= 1'b0;
    end else begin
      seen_q <= counting;
      if (counting && tick && !armed) begin
        if (cnt_q == LAST) armed <= 1'b1;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr) |=> armed);
  // R3
  arm_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> seen_q);
endmodule

// File: rtl/pgs_fault_latches.sv
module pgs_fault_latches #(
  parameter int CL_TRIP = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ovp_abs,
  input  logic win_hi,
  input  logic win_ovp_en,
  input  logic win_lo,
  input  logic ss_done,
  input  logic tick,
  input  logic ilim_evt,
  input  logic otemp,
  output logic ovp_q,
  output logic cl_q,
  output logic ot_q
);
  localparam int CW = $clog2(CL_TRIP + 1);
  localparam logic [CW-1:0] LAST = CW'(CL_TRIP - 1);

  logic [CW-1:0] run_q;
  logic          cl_arm;

  assign cl_arm = win_lo & ss_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovp_q <= 1'b0;
      cl_q  <= 1'b0;
      ot_q  <= 1'b0;
      run_q <= '0;
    end else if (clr) begin
      ovp_q <= 1'b0;
      cl_q  <= 1'b0;
      ot_q  <= 1'b0;
      run_q <= '0;
    end else begin
      if (ovp_abs || (win_hi && win_ovp_en)) ovp_q <= 1'b1;
      if (otemp)                             ot_q  <= 1'b1;
      if (!cl_arm) begin
        run_q <= '0;
      end else if (tick) begin
        if (!ilim_evt)          run_q <= '0;
        else if (run_q == LAST) cl_q  <= 1'b1;
        else                    run_q <= run_q + 1'b1;
      end
    end
  end

  // R6
  abs_ovp_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_abs && !clr) |=> ovp_q);
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovp_q || cl_q || ot_q) && !clr) |=>
      (ovp_q || cl_q || ot_q));
  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !(ovp_q || cl_q || ot_q));
  // R7
  cl_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cl_q) |-> $past(cl_arm && tick && ilim_evt));
endmodule

// File: rtl/pg_fault_supervisor.sv
module pg_fault_supervisor
  import pgs_pkg::*;
#(
  parameter int BLANK_CYC = 62,
  parameter int DLY_CYC   = 1007,
  parameter int CL_TRIP   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       uvlo,
  input  logic       cyc_tick,
  input  logic       win_ok,
  input  logic       win_hi,
  input  logic       win_lo,
  input  logic       ovp_abs,
  input  logic       ilim_evt,
  input  logic       otemp,
  input  logic       ss_done,
  input  logic       trans_act,
  input  logic       boot_reached,
  output logic       pg_early,
  output logic       pg_late,
  output logic [2:0] gate_cmd
);
  logic      off;
  logic      blanking;
  logic      armed;
  logic      ovp_q, cl_q, ot_q;
  logic      fault_any;
  logic      started_q;
  logic      pg_q;
  logic      pg_d;
  gate_cmd_e cmd;

  assign off       = ~en | uvlo;
  assign fault_any = ovp_q | cl_q | ot_q;

  pgs_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .clr(off), .trans_act(trans_act),
    .tick(cyc_tick), .blanking(blanking)
  );

  pgs_delay_timer #(.DLY_CYC(DLY_CYC)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(off), .pg_early(pg_q),
    .tick(cyc_tick), .armed(armed)
  );

  pgs_fault_latches #(.CL_TRIP(CL_TRIP)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(off), .ovp_abs(ovp_abs),
    .win_hi(win_hi), .win_ovp_en(ss_done & ~trans_act & ~blanking),
    .win_lo(win_lo), .ss_done(ss_done), .tick(cyc_tick),
    .ilim_evt(ilim_evt), .otemp(otemp),
    .ovp_q(ovp_q), .cl_q(cl_q), .ot_q(ot_q)
  );

  always_comb begin
    if (fault_any)                       pg_d = 1'b0;
    else if (!(started_q | boot_reached)) pg_d = 1'b0;
    else if (blanking)                   pg_d = 1'b1;
    else                                 pg_d = win_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pg_q      <= 1'b0;
    end else if (off) begin
      started_q <= 1'b0;
      pg_q      <= 1'b0;
    end else begin
      started_q <= started_q | boot_reached;
      pg_q      <= pg_d;
    end
  end

  always_comb begin
    if (off)           cmd = CMD_ALL_OFF;
    else if (ot_q)     cmd = CMD_ALL_OFF;
    else if (ovp_q)    cmd = CMD_HOLD_LOW;
    else if (cl_q)     cmd = CMD_ALL_OFF;
    else if (ilim_evt) cmd = CMD_HS_OFF;
    else               cmd = CMD_NONE;
  end

  assign gate_cmd = cmd;
  assign pg_early = pg_q;
  assign pg_late  = armed & pg_q;

  // R10
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_cmd));
  // R1
  off_drops_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !pg_early);
  // R11
  fault_drops_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !off) |=> !pg_early);
  // R4
  blank_holds_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && started_q && !fault_any && !off) |=> pg_early);
endmodule

// File: tb/test_pg_fault_supervisor.sv
module test_pg_fault_supervisor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, en, uvlo, cyc_tick, win_ok, win_hi, win_lo, ovp_abs;
  logic ilim_evt, otemp, ss_done, trans_act, boot_reached;
  logic pg_early, pg_late;
  logic [2:0] gate_cmd;

  int nchk = 0, nfail = 0, tick_div = 1;
  bit done = 0;

  // behavioural reference state
  bit m_started, m_pg, m_seen, m_arm, m_trq, m_ovp, m_cl, m_ot;
  int m_dcnt, m_blank, m_clcnt;
  bit t_off, t_blk, t_flt, t_pgo;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_fault_supervisor i_pg_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo(uvlo), .cyc_tick(cyc_tick),
    .win_ok(win_ok), .win_hi(win_hi), .win_lo(win_lo), .ovp_abs(ovp_abs),
    .ilim_evt(ilim_evt), .otemp(otemp), .ss_done(ss_done),
    .trans_act(trans_act), .boot_reached(boot_reached),
    .pg_early(pg_early), .pg_late(pg_late), .gate_cmd(gate_cmd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cmd();
    if (!en || uvlo) return 1;
    if (m_ot)        return 1;
    if (m_ovp)       return 2;
    if (m_cl)        return 1;
    if (ilim_evt)    return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_started = 0; m_pg = 0; m_seen = 0; m_arm = 0; m_trq = 0;
      m_ovp = 0; m_cl = 0; m_ot = 0; m_dcnt = 0; m_blank = 0; m_clcnt = 0;
    end else begin
      t_off = !en || uvlo;
      t_blk = m_blank > 0;
      t_flt = m_ovp || m_cl || m_ot;
      t_pgo = m_pg;
      if (t_off) begin
        m_started = 0; m_pg = 0; m_seen = 0; m_arm = 0;
        m_ovp = 0; m_cl = 0; m_ot = 0; m_dcnt = 0; m_blank = 0; m_clcnt = 0;
      end else begin
        if (ovp_abs || (win_hi && ss_done && !trans_act && !t_blk)) m_ovp = 1;
        if (otemp) m_ot = 1;
        if (!(win_lo && ss_done)) m_clcnt = 0;
        else if (cyc_tick) begin
          if (!ilim_evt)         m_clcnt = 0;
          else if (m_clcnt == 31) m_cl = 1;
          else                   m_clcnt++;
        end
        m_pg = t_flt ? 0 : !(m_started || boot_reached) ? 0 : t_blk ? 1 : win_ok;
        m_started = m_started || boot_reached;
        if ((m_seen || t_pgo) && cyc_tick && !m_arm) begin
          if (m_dcnt == 1006) m_arm = 1;
          else                m_dcnt++;
        end
        m_seen = m_seen || t_pgo;
        if (trans_act && !m_trq)           m_blank = 62;
        else if (m_blank > 0 && cyc_tick)  m_blank--;
      end
      m_trq = trans_act;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 pg_early vs model", pg_early, m_pg);
      chk("R3 pg_late vs model", pg_late, m_arm && m_pg);
      chk("R10 gate_cmd vs model", gate_cmd, exp_cmd());
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_tick = ((i % tick_div) == 0);
      step(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; uvlo = 0; cyc_tick = 0; win_ok = 0; win_hi = 0;
    win_lo = 0; ovp_abs = 0; ilim_evt = 0; otemp = 0; ss_done = 0;
    trans_act = 0; boot_reached = 0;
    step(3);
    chk("R1 reset pg_early", pg_early, 0);
    chk("R1 reset pg_late", pg_late, 0);
    chk("R1 disabled gate_cmd all_off", gate_cmd, 1);
    rst_n = 1; en = 1; win_ok = 1;
    run(2);
    chk("R2 no good before boot", pg_early, 0);
    chk("R10 idle gate_cmd none", gate_cmd, 0);
    boot_reached = 1; run(1);
    chk("R2 good after boot", pg_early, 1);
    win_ok = 0; run(1);
    chk("R2 follows window low", pg_early, 0);
    win_ok = 1; run(1);
    chk("R2 follows window high", pg_early, 1);
    run(500);
    chk("R3 late not yet", pg_late, 0);
    run(600);
    chk("R3 late after 1007 ticks", pg_late, 1);

    // blanking counted in switching cycles (tick every second clock)
    ss_done = 1; tick_div = 2; trans_act = 1; win_ok = 0; win_hi = 1;
    run(100);
    chk("R4 early held during blanking", pg_early, 1);
    chk("R5 window ovp ignored in transition", gate_cmd, 0);
    trans_act = 0; run(20);
    chk("R5 window ovp ignored while blanking", gate_cmd, 0);
    chk("R4 still blanked", pg_early, 1);
    win_hi = 0; run(20);
    chk("R4 blanking expired", pg_early, 0);
    tick_div = 1; win_ok = 1; run(2);

    // window over-voltage
    ss_done = 0; win_hi = 1; run(5);
    chk("R5 ignored in soft-start", gate_cmd, 0);
    ss_done = 1; run(2);
    chk("R5 window ovp hold_low", gate_cmd, 2);
    chk("R11 good drops on latch", pg_early, 0);
    win_hi = 0; run(10);
    chk("R9 ovp latch persists", gate_cmd, 2);
    en = 0; run(1);
    chk("R1 disable all_off", gate_cmd, 1);
    en = 1; run(2);
    chk("R9 enable low clears", gate_cmd, 0);

    // absolute over-voltage during a transition
    trans_act = 1; ovp_abs = 1; run(2);
    chk("R6 absolute ovp in transition", gate_cmd, 2);
    ovp_abs = 0; trans_act = 0; uvlo = 1; run(2);
    chk("R1 lockout all_off", gate_cmd, 1);
    chk("R1 lockout pg_early", pg_early, 0);
    uvlo = 0; run(3);
    chk("R9 lockout not latched", gate_cmd, 0);
    chk("R9 good returns after lockout", pg_early, 1);

    // current-limit run
    win_ok = 0; win_lo = 1; ilim_evt = 1; #1;
    chk("R10 live limit hs_off", gate_cmd, 4);
    run(31);
    ilim_evt = 0; run(1);
    chk("R7 run broken by quiet tick", gate_cmd, 0);
    ilim_evt = 1; run(31);
    chk("R7 31 pulses no trip", gate_cmd, 4);
    run(1);
    chk("R7 32nd pulse trips", gate_cmd, 1);
    ilim_evt = 0; run(5);
    chk("R7 trip latched", gate_cmd, 1);
    en = 0; run(1); en = 1; ss_done = 0; ilim_evt = 1;
    run(40);
    chk("R7 inhibited in soft-start", gate_cmd, 4);
    ss_done = 1; run(20);
    win_lo = 0; run(1); win_lo = 1;
    run(20);
    chk("R7 window return restarts run", gate_cmd, 4);
    ilim_evt = 0; win_lo = 0; win_ok = 1; run(2);
    chk("R7 no trip after restart", gate_cmd, 0);

    // over-temperature priority
    otemp = 1; ovp_abs = 1; run(1);
    otemp = 0; ovp_abs = 0; run(3);
    chk("R8 over-temp wins all_off", gate_cmd, 1);
    chk("R11 early low under latch", pg_early, 0);
    chk("R11 late low under latch", pg_late, 0);
    en = 0; run(1); en = 1; run(2);
    chk("R9 over-temp cleared by enable", gate_cmd, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule